// File: doc/BRIEF.md
# Parallel Group Commit Mask Generator

This block sits in the issue stage of a machine that fetches several instructions per cycle and runs them on separate lanes. Each instruction carries one group-marker bit. A run of consecutive instructions whose marker bits are equal forms a group that may execute together. A change in the marker starts a new group. Given the marker bits of the fetched lanes in program order, the block works out which lanes may commit their results this cycle. It also gives how many lanes that is, and where the program counter goes next.

A break at any lane cancels that lane and every lane after it, in the manner of a wired-AND chain. The same code therefore serves any lane count of two or more. A lane that holds no fetched instruction (past the end of memory) counts as a break. A committed lane that takes a jump ends the group after itself, and the program counter then loads that lane's target instead of stepping forward. The logic is purely combinational and holds no state. The pins carry control and status only, so there is no valid/ready handshake and no back-pressure: the outputs follow the inputs in the same cycle.

Top module: `epic_commit_unit`

## Requirements
- R1: Lane 0 always commits (`commit_mask[0]` is 1), whatever its marker bit, jump flag or the other inputs.
- R2: The commit mask is always a run of ones starting at lane 0 (thermometer form). A lane i≥1 commits only if lane i-1 commits.
- R3: If the marker bit of lane i (i≥1) differs from that of lane i-1, then lanes i and above do not commit.
- R4: If `lane_valid[i]` is low for a lane i≥1, then lanes i and above do not commit. Lane 0 has no valid bit.
- R5: If a committed lane k has `jump_taken[k]` high, lane k still commits and lanes k+1 and above do not. A jump flag on a lane that does not commit has no effect on any output.
- R6: `commit_count` equals the number of committed lanes. This is the index of the first lane that does not commit, or LANES if all lanes commit.
- R7: When no committed lane takes a jump, `redirect` is 0 and `pc_next` equals `pc_now + commit_count`, modulo 2^ADDR_W.
- R8: When a committed lane k takes a jump, `redirect` is 1 and `pc_next` equals lane k's target, which sits in `jump_target[k*ADDR_W +: ADDR_W]`.
- R9: All outputs are combinational functions of the present inputs. They change without any clock edge and carry no state over from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| set_bits | input | LANES | Group-marker bit of each lane; bit i is lane i, in program order |
| lane_valid | input | LANES-1 | Lane holds a fetched instruction; indexed [LANES-1:1], lane 0 has none |
| jump_taken | input | LANES | Lane's instruction is a jump whose condition holds |
| jump_target | input | LANES*ADDR_W | Jump address of each lane, lane k at bits k*ADDR_W upward |
| pc_now | input | ADDR_W | Address of the instruction in lane 0 |
| commit_mask | output | LANES | Lanes whose results are written this cycle |
| commit_count | output | $clog2(LANES+1) | Number of committed lanes |
| pc_next | output | ADDR_W | Address of the next fetch |
| redirect | output | 1 | A committed lane took a jump |

## Verification
A marker-bit break and a jump cut can hit the same cycle, and the mask must then end at whichever cut comes first in lane order. The bench provokes both orders. In one case a jump sits on an early lane with a marker change further on. In the other a jump sits on a lane that the marker change has already cancelled, where the flag must be ignored and the count must step the program counter. Each case is judged against the expected mask, the count, the redirect flag and the next address. An exhaustive sweep then checks every mix of the two against a reference built from the requirements.

// File: rtl/epic_commit_pkg.sv
package epic_commit_pkg;
  // Width needed to hold a lane count from 0 to n inclusive.
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/commit_break_detect.sv
// One cut flag per lane. A cut at lane i ends the group before lane i.
module commit_break_detect #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] set_bits,
  input  logic [LANES-1:1] lane_valid,
  input  logic [LANES-2:0] jump_prev,
  output logic [LANES-1:1] cut
);
  for (genvar i = 1; i < LANES; i++) begin : g_cut
    assign cut[i] = ~lane_valid[i] | (set_bits[i] ^ set_bits[i-1]) | jump_prev[i-1];
  end
endmodule

// File: rtl/commit_chain.sv
// Wired-AND style chain: a cut disables its lane and every later lane.
module commit_chain #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:1] cut,
  output logic [LANES-1:0] mask
);
  assign mask[0] = 1'b1;
  for (genvar i = 1; i < LANES; i++) begin : g_chain
    assign mask[i] = mask[i-1] & ~cut[i];
  end
endmodule

// File: rtl/commit_count_enc.sv
// Turns the thermometer mask into the index of its first zero.
module commit_count_enc #(
  parameter int LANES = 4,
  parameter int CW    = 3
) (
  input  logic [LANES-1:0] mask,
  output logic [CW-1:0]    count
);
  always_comb begin
    count = CW'(LANES);
    for (int i = LANES - 1; i >= 1; i--) begin
      if (!mask[i]) count = CW'(i);
    end
  end
endmodule

// File: rtl/pc_advance.sv
// Next fetch address: the taken jump of the last committed lane, or a step.
module pc_advance #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 8,
  parameter int CW     = 3
) (
  input  logic [LANES-1:0]        mask,
  input  logic [LANES-1:0]        jump_taken,
  input  logic [LANES*ADDR_W-1:0] targets,
  input  logic [ADDR_W-1:0]       pc_now,
  input  logic [CW-1:0]           count,
  output logic [ADDR_W-1:0]       pc_next,
  output logic                    redirect
);
  logic [ADDR_W-1:0] tgt_sel;

  always_comb begin
    redirect = 1'b0;
    tgt_sel  = '0;
    for (int i = 0; i < LANES; i++) begin
      if (mask[i] && jump_taken[i]) begin
        redirect = 1'b1;
        tgt_sel  = targets[i*ADDR_W +: ADDR_W];
      end
    end
    pc_next = redirect ? tgt_sel : pc_now + ADDR_W'(count);
  end
endmodule

// File: rtl/epic_commit_unit.sv
module epic_commit_unit #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 8,
  localparam int CW    = epic_commit_pkg::count_width(LANES)
) (
  input  logic [LANES-1:0]        set_bits,
  input  logic [LANES-1:1]        lane_valid,
  input  logic [LANES-1:0]        jump_taken,
  input  logic [LANES*ADDR_W-1:0] jump_target,
  input  logic [ADDR_W-1:0]       pc_now,
  output logic [LANES-1:0]        commit_mask,
  output logic [CW-1:0]           commit_count,
  output logic [ADDR_W-1:0]       pc_next,
  output logic                    redirect
);
  logic [LANES-1:1] cut;

  commit_break_detect #(.LANES(LANES)) brk_i (
    .set_bits   (set_bits),
    .lane_valid (lane_valid),
    .jump_prev  (jump_taken[LANES-2:0]),
    .cut        (cut)
  );

  commit_chain #(.LANES(LANES)) chain_i (
    .cut  (cut),
    .mask (commit_mask)
  );

  commit_count_enc #(.LANES(LANES), .CW(CW)) cnt_i (
    .mask  (commit_mask),
    .count (commit_count)
  );

  pc_advance #(.LANES(LANES), .ADDR_W(ADDR_W), .CW(CW)) pc_i (
    .mask       (commit_mask),
    .jump_taken (jump_taken),
    .targets    (jump_target),
    .pc_now     (pc_now),
    .count      (commit_count),
    .pc_next    (pc_next),
    .redirect   (redirect)
  );
endmodule

// File: rtl/epic_commit_unit_chk.sv
module epic_commit_unit_chk #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 8,
  localparam int CW    = epic_commit_pkg::count_width(LANES)
) (
  input logic [LANES-1:0]        set_bits,
  input logic [LANES-1:1]        lane_valid,
  input logic [LANES-1:0]        jump_taken,
  input logic [LANES*ADDR_W-1:0] jump_target,
  input logic [ADDR_W-1:0]       pc_now,
  input logic [LANES-1:0]        commit_mask,
  input logic [CW-1:0]           commit_count,
  input logic [ADDR_W-1:0]       pc_next,
  input logic                    redirect
);
  logic [LANES-1:0] mask_inc;
  assign mask_inc = commit_mask + 1'b1;

  always_comb begin
    // R1
    lane0_commit_chk: assert (commit_mask[0]);
    // R2
    thermo_mask_chk: assert ((mask_inc & commit_mask) == '0);
    // R6
    count_match_chk: assert ($countones(commit_mask) == int'(commit_count));
    // R7
    if (!redirect) begin
      step_pc_chk: assert (pc_next == pc_now + ADDR_W'(commit_count));
    end
    // R8
    redirect_src_chk: assert (redirect == |(commit_mask & jump_taken));
    if (redirect) begin
      // R8
      redirect_tgt_chk: assert (pc_next == jump_target[(int'(commit_count) - 1)*ADDR_W +: ADDR_W]);
    end
  end

  for (genvar i = 1; i < LANES; i++) begin : g_lane
    always_comb begin
      if ((set_bits[i] != set_bits[i-1]) || !lane_valid[i]) begin
        // R3
        mismatch_cut_chk: assert (!commit_mask[i]);
      end
      if (commit_mask[i-1] && jump_taken[i-1]) begin
        // R5
        jump_cut_chk: assert (!commit_mask[i]);
      end
    end
  end
endmodule

bind epic_commit_unit epic_commit_unit_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/epic_commit_unit_tb_top.sv
module epic_commit_unit_tb_top;
  localparam int LANES  = 4;
  localparam int ADDR_W = 8;
  localparam int CW     = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [LANES-1:0]        set_bits;
  logic [LANES-1:1]        lane_valid;
  logic [LANES-1:0]        jump_taken;
  logic [LANES*ADDR_W-1:0] jump_target;
  logic [ADDR_W-1:0]       pc_now;
  logic [LANES-1:0]        commit_mask;
  logic [CW-1:0]           commit_count;
  logic [ADDR_W-1:0]       pc_next;
  logic                    redirect;

  epic_commit_unit #(.LANES(LANES), .ADDR_W(ADDR_W)) dut_i (.*);

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Nibbles: marker bits, valid (bit 0 unused), jump flags, expected mask.
  localparam logic [15:0] VECS [0:15] = '{
    16'h0F0F, 16'hFF0F, 16'h2F01, 16'hCF03,
    16'h8F07, 16'h0707, 16'h0D01, 16'h0F11,
    16'h0F47, 16'h0F8F, 16'h2F41, 16'h1E01,
    16'h5F01, 16'h0F63, 16'h8F23, 16'h4F43
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] tgt_of(input int k);
    return ADDR_W'(8'h40 + k * 8'h11);
  endfunction

  // Reference from the requirements: stop at the first break in lane order.
  function automatic logic [LANES-1:0] ref_mask(input logic [LANES-1:0] s,
                                                input logic [LANES-1:1] v,
                                                input logic [LANES-1:0] j);
    logic [LANES-1:0] m;
    bit live;
    m = 4'b0001;
    live = 1'b1;
    for (int i = 1; i < LANES; i++) begin
      if (!v[i] || s[i] != s[i-1] || j[i-1]) live = 1'b0;
      m[i] = live;
    end
    return m;
  endfunction

  task automatic judge(input logic [LANES-1:0] em, input string tag);
    logic [LANES-1:0] hit;
    int cnt;
    logic [ADDR_W-1:0] epc;
    bit er;
    cnt = $countones(em);
    hit = em & jump_taken;
    er  = |hit;
    epc = pc_now + ADDR_W'(cnt);
    for (int k = 0; k < LANES; k++) if (hit[k]) epc = tgt_of(k);
    check(commit_mask == em, {tag, " R2 R3 R4 R5 mask"}, int'(commit_mask), int'(em));
    check(commit_mask[0], {tag, " R1 lane0"}, int'(commit_mask[0]), 1);
    check(int'(commit_count) == cnt, {tag, " R6 count"}, int'(commit_count), cnt);
    check(redirect == er, {tag, " R7 R8 redirect"}, int'(redirect), int'(er));
    check(pc_next == epc, {tag, " R7 R8 pc_next"}, int'(pc_next), int'(epc));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < LANES; k++) jump_target[k*ADDR_W +: ADDR_W] = tgt_of(k);
    // Idle inputs: all zero, lanes invalid -> only lane 0 (R1, R4).
    set_bits = '0; lane_valid = '0; jump_taken = '0; pc_now = 8'h00;
    @(negedge clk); #1;
    judge(4'b0001, "idle R1 R4");

    // Table walk, including break-plus-jump in the same cycle.
    pc_now = 8'hFD;
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      set_bits   = VECS[n][15:12];
      lane_valid = VECS[n][11:9];
      jump_taken = VECS[n][7:4];
      #1;
      judge(VECS[n][3:0], $sformatf("vec%0d", n));
    end

    // R7: wrap of the program counter with a full group.
    @(negedge clk);
    set_bits = 4'hF; lane_valid = 3'b111; jump_taken = '0; pc_now = 8'hFE;
    #1;
    check(pc_next == 8'h02, "R7 wrap", int'(pc_next), 8'h02);

    // R9: outputs change with inputs without a clock edge.
    @(posedge clk); #2;
    set_bits = 4'b0100;
    #1;
    check(commit_mask == 4'b0011, "R9 comb change", int'(commit_mask), 4'b0011);
    set_bits = 4'b0000;
    #1;
    check(commit_mask == 4'b1111, "R9 no state", int'(commit_mask), 4'b1111);

    // Exhaustive sweep against the reference model.
    pc_now = 8'h7C;
    for (int s = 0; s < 16; s++) begin
      for (int v = 0; v < 8; v++) begin
        for (int j = 0; j < 16; j++) begin
          @(negedge clk);
          set_bits = 4'(s); lane_valid = 3'(v); jump_taken = 4'(j);
          #1;
          judge(ref_mask(4'(s), 3'(v), 4'(j)), "sweep");
        end
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule